// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is the storage end of an on-chip trace path. Trace words arrive one per cycle with a valid strobe. While capture is on, each word is stored in an internal RAM at a write pointer that moves up by one and wraps at the RAM depth. A sticky flag records that the pointer has wrapped, which tells software that the oldest data has been overwritten.

Software reaches the block through a simple register bus: one request strobe, one write strobe, a 12-bit byte offset, and write and read data. Reads return data combinationally in the same cycle. Through this bus software can:
- move both pointers;
- stream words out through an auto-advancing read port;
- stream words in through a write port, for example to clear the RAM;
- control capture.

A shutdown sequencer can stop capture in two ways. The first stops a programmed number of words after a trigger input. The second runs a manual flush, which pads the write position with zero words up to the next 4-word frame boundary, and then stops when the flush is done. A status bit reports that the capture side has stopped. The RAM depth must be a power of two and at least 4.

Top module: `trace_ring_buf`

## Requirements
- R1: The register at offset 0x004 reads as the RAM depth in words, with bit 31 clear. Reads of offsets that are not mapped return 0. Writes to them change no state.
- R2: While bit 0 of the control register (0x020) is 1, each trace word with `trc_valid` high is stored at the write pointer, and the pointer advances by one, wrapping from depth-1 to 0. While that bit is 0, trace words are dropped.
- R3: Bit 0 of the status register (0x00C) becomes 1 when any store lands at address depth-1. It stays 1, including across capture re-enable, until the write pointer register (0x018) is written.
- R4: A read of the data port (0x010) returns the word at the read pointer (0x014) and advances that pointer by one, wrapping at the depth. The read pointer register can be written and read.
- R5: A write to the data port (0x024) stores the bus word at the write pointer and advances it. If a trace word arrives in the same cycle, the bus write wins and the trace word is dropped.
- R6: The formatter control register (0x304) holds bit 0 (format enable), bit 12 (stop after flush) and bit 13 (stop on trigger), and reads them back.
- R7: Writing 1 to bit 6 of 0x304 starts a flush. Bit 6 reads 1 while the flush runs. The flush writes one zero word per cycle until the write pointer is a multiple of 4, then bit 6 clears. Trace words are dropped during a flush.
- R8: If bit 12 of 0x304 is set, completing a flush stops capture. Bit 1 of the formatter status register (0x300) then reads 1, and later trace words are dropped.
- R9: If bit 13 of 0x304 is set, a trigger input seen while capturing causes exactly N further trace words to be stored, where N is the trigger counter value (0x01C). Capture then stops and 0x300 bit 1 reads 1. If bit 13 is clear, the trigger has no effect.
- R10: Bit 1 of 0x300 also reads 1 whenever the control bit is 0, and bit 0 of 0x300 mirrors the flush-busy state. Writing the control register with bit 0 = 1 clears a stop and resumes capture.
- R11: After reset, the pointers, wrap flag, control register, formatter control bits and trigger counter are all 0, and no flush is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the request cycle |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trig | input | 1 | Trigger event |

## Verification
The bench drives the write pointer across the last RAM address, both from the bus and from trace input, and checks that the wrap flag survives a capture restart. A design that cleared the flag on re-enable would hide overwritten data from software.

A flush is started from an unaligned pointer, and a trace word is offered while the flush runs. The bench then checks three things: exactly three zero pads, a pointer of 4, and that the busy bit clears. A design that stopped one word early, or that let trace words in during the flush, would leave the pointer off a frame boundary.

The trigger tests cover a count of 3, a count of 0, and stop-on-trigger disabled. An off-by-one in the post-trigger count shows up directly as a wrong write pointer.

Finally, a bus data write and a trace word are driven in the same cycle. A design without a defined priority would either lose the bus word or store both.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_DEPTH  = 12'h004;
  localparam logic [REG_AW-1:0] OFS_STAT   = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_RDATA  = 12'h010;
  localparam logic [REG_AW-1:0] OFS_RPTR   = 12'h014;
  localparam logic [REG_AW-1:0] OFS_WPTR   = 12'h018;
  localparam logic [REG_AW-1:0] OFS_TRGCNT = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h020;
  localparam logic [REG_AW-1:0] OFS_WDATA  = 12'h024;
  localparam logic [REG_AW-1:0] OFS_FMTST  = 12'h300;
  localparam logic [REG_AW-1:0] OFS_FMTCTL = 12'h304;

  localparam int BIT_FMT_EN     = 0;
  localparam int BIT_FLUSH      = 6;
  localparam int BIT_STOP_FLUSH = 12;
  localparam int BIT_STOP_TRIG  = 13;

  localparam int FRAME_WORDS = 4;
  localparam int FRAME_LSB   = $clog2(FRAME_WORDS);
endpackage

// File: rtl/trace_ring_mem.sv
module trace_ring_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/trace_ring_seq.sv
module trace_ring_seq #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          stop_trig_en,
  input  logic          stop_flush_en,
  input  logic          flush_start,
  input  logic          restart,
  input  logic          trig_in,
  input  logic [CW-1:0] trig_cnt,
  input  logic          word_stored,
  input  logic          frame_aligned,
  output logic          flush_busy,
  output logic          stopped,
  output logic          halt
);
  logic          busy_q, busy_d;
  logic          stop_q, stop_d;
  logic          armed_q, armed_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          arm, flush_done, rem_zero;

  assign rem_zero   = (rem_q == '0);
  assign flush_done = busy_q & frame_aligned & ~flush_start;
  assign arm        = trig_in & stop_trig_en & cap_en & ~stop_q & ~armed_q;

  always_comb begin
    busy_d  = busy_q;
    stop_d  = stop_q;
    armed_d = armed_q;
    rem_d   = rem_q;
    if (flush_start)     busy_d = 1'b1;
    else if (flush_done) busy_d = 1'b0;
    if (restart) begin
      stop_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      if ((armed_q & rem_zero) | (flush_done & stop_flush_en)) stop_d = 1'b1;
      if (arm)                       armed_d = 1'b1;
      else if (armed_q & rem_zero)   armed_d = 1'b0;
    end
    if (arm)                                        rem_d = trig_cnt;
    else if (armed_q & word_stored & ~rem_zero)     rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stop_q  <= 1'b0;
      armed_q <= 1'b0;
      rem_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      stop_q  <= stop_d;
      armed_q <= armed_d;
      rem_q   <= rem_d;
    end
  end

  assign flush_busy = busy_q;
  assign stopped    = stop_q;
  assign halt       = stop_q | (armed_q & rem_zero);
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trig
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          cap_en_q, fmt_en_q, stop_flush_q, stop_trig_q, full_q;
  logic [31:0]   trig_cnt_q;
  logic [AW-1:0] wptr_q, rptr_q, wptr_d, rptr_d;
  logic          full_d;

  logic bus_wr, bus_rd;
  logic wr_wptr, wr_rptr, wr_data, wr_ctrl, wr_fmtctl, wr_trg, rd_data;
  logic flush_busy, stopped, halt;
  logic pad_we, trc_store, mem_we;
  logic [31:0] mem_wd, mem_rd;

  assign bus_wr    = reg_req & reg_we;
  assign bus_rd    = reg_req & ~reg_we;
  assign wr_wptr   = bus_wr & (reg_addr == OFS_WPTR);
  assign wr_rptr   = bus_wr & (reg_addr == OFS_RPTR);
  assign wr_data   = bus_wr & (reg_addr == OFS_WDATA);
  assign wr_ctrl   = bus_wr & (reg_addr == OFS_CTRL);
  assign wr_fmtctl = bus_wr & (reg_addr == OFS_FMTCTL);
  assign wr_trg    = bus_wr & (reg_addr == OFS_TRGCNT);
  assign rd_data   = bus_rd & (reg_addr == OFS_RDATA);

  trace_ring_seq #(.CW(32)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (cap_en_q),
    .stop_trig_en (stop_trig_q),
    .stop_flush_en(stop_flush_q),
    .flush_start  (wr_fmtctl & reg_wdata[BIT_FLUSH]),
    .restart      (wr_ctrl & reg_wdata[0]),
    .trig_in      (trc_trig),
    .trig_cnt     (trig_cnt_q),
    .word_stored  (trc_store),
    .frame_aligned(wptr_q[FRAME_LSB-1:0] == '0),
    .flush_busy   (flush_busy),
    .stopped      (stopped),
    .halt         (halt)
  );

  // Store source priority: bus write port, then flush padding, then trace.
  assign pad_we    = flush_busy & (wptr_q[FRAME_LSB-1:0] != '0) & ~wr_data;
  assign trc_store = trc_valid & cap_en_q & ~halt & ~flush_busy & ~wr_data;
  assign mem_we    = wr_data | pad_we | trc_store;
  assign mem_wd    = wr_data ? reg_wdata : (pad_we ? 32'h0 : trc_data);

  trace_ring_mem #(.DW(32), .DEPTH(DEPTH)) mem_i (
    .clk  (clk),
    .we   (mem_we),
    .waddr(wptr_q),
    .wdata(mem_wd),
    .raddr(rptr_q),
    .rdata(mem_rd)
  );

  always_comb begin
    wptr_d = wptr_q;
    full_d = full_q;
    if (wr_wptr) begin
      wptr_d = reg_wdata[AW-1:0];
      full_d = 1'b0;
    end else if (mem_we) begin
      wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (wptr_q == LAST) full_d = 1'b1;
    end
    rptr_d = rptr_q;
    if (wr_rptr)      rptr_d = reg_wdata[AW-1:0];
    else if (rd_data) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q       <= '0;
      rptr_q       <= '0;
      full_q       <= 1'b0;
      cap_en_q     <= 1'b0;
      fmt_en_q     <= 1'b0;
      stop_flush_q <= 1'b0;
      stop_trig_q  <= 1'b0;
      trig_cnt_q   <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      full_q <= full_d;
      if (wr_ctrl) cap_en_q <= reg_wdata[0];
      if (wr_trg)  trig_cnt_q <= reg_wdata;
      if (wr_fmtctl) begin
        fmt_en_q     <= reg_wdata[BIT_FMT_EN];
        stop_flush_q <= reg_wdata[BIT_STOP_FLUSH];
        stop_trig_q  <= reg_wdata[BIT_STOP_TRIG];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (bus_rd) begin
      unique case (reg_addr)
        OFS_DEPTH:  reg_rdata = 32'(DEPTH) & 32'h7FFF_FFFF;
        OFS_STAT:   reg_rdata = {31'b0, full_q};
        OFS_RDATA:  reg_rdata = mem_rd;
        OFS_RPTR:   reg_rdata = 32'(rptr_q);
        OFS_WPTR:   reg_rdata = 32'(wptr_q);
        OFS_TRGCNT: reg_rdata = trig_cnt_q;
        OFS_CTRL:   reg_rdata = {31'b0, cap_en_q};
        OFS_FMTST:  reg_rdata = {30'b0, stopped | ~cap_en_q, flush_busy};
        OFS_FMTCTL: reg_rdata = {18'b0, stop_trig_q, stop_flush_q, 5'b0,
                                 flush_busy, 5'b0, fmt_en_q};
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] wptr,
  input logic          full,
  input logic          flush_busy,
  input logic          stopped,
  input logic          trc_store,
  input logic          mem_we,
  input logic          wr_wptr
);
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full && !wr_wptr |=> full); // R3
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !wr_wptr |=> wptr == AW'($past(wptr) + 1'b1)); // R2
  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we && !wr_wptr |=> $stable(wptr)); // R2
  AST_FLUSH_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy && (wptr[1:0] != 2'b00) |-> mem_we); // R7
  AST_FLUSH_NO_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !trc_store); // R7
  AST_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !trc_store); // R8
endmodule

bind trace_ring_buf trace_ring_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wptr      (wptr_q),
  .full      (full_q),
  .flush_busy(flush_busy),
  .stopped   (stopped),
  .trc_store (trc_store),
  .mem_we    (mem_we),
  .wr_wptr   (wr_wptr)
);

// File: tb/trace_ring_buf_tb_top.sv
`timescale 1ns/1ps
module trace_ring_buf_tb_top;
  localparam int DEPTH = 16;
  localparam int NVEC  = 24;

  logic        clk, rst_n;
  logic        reg_req, reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        trc_valid, trc_trig;
  logic [31:0] trc_data;

  int n_chk, n_fail;

  trace_ring_buf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trig(trc_trig)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {op(1=write,0=read-check), req, offset, write data, expected}
  localparam logic [81:0] VEC [NVEC] = '{
    {2'd0, 4'd1,  12'h004, 32'h0, 32'd16},       // R1 depth
    {2'd0, 4'd11, 12'h00C, 32'h0, 32'h0},        // R11 status
    {2'd0, 4'd11, 12'h018, 32'h0, 32'h0},        // R11 wptr
    {2'd0, 4'd11, 12'h014, 32'h0, 32'h0},        // R11 rptr
    {2'd0, 4'd11, 12'h020, 32'h0, 32'h0},        // R11 ctrl
    {2'd0, 4'd11, 12'h304, 32'h0, 32'h0},        // R11 fmt ctrl
    {2'd0, 4'd11, 12'h01C, 32'h0, 32'h0},        // R11 trig cnt
    {2'd0, 4'd10, 12'h300, 32'h0, 32'h2},        // R10 stopped while off
    {2'd0, 4'd1,  12'h100, 32'h0, 32'h0},        // R1 unmapped read
    {2'd1, 4'd1,  12'h100, 32'hFFFF, 32'h0},
    {2'd0, 4'd1,  12'h018, 32'h0, 32'h0},        // R1 unmapped write ignored
    {2'd1, 4'd5,  12'h024, 32'h11, 32'h0},
    {2'd1, 4'd5,  12'h024, 32'h22, 32'h0},
    {2'd1, 4'd5,  12'h024, 32'h33, 32'h0},
    {2'd0, 4'd5,  12'h018, 32'h0, 32'd3},        // R5 wptr advanced
    {2'd1, 4'd4,  12'h014, 32'h0, 32'h0},
    {2'd0, 4'd4,  12'h010, 32'h0, 32'h11},       // R4 read port
    {2'd0, 4'd4,  12'h010, 32'h0, 32'h22},       // R4 read port
    {2'd0, 4'd4,  12'h014, 32'h0, 32'd2},        // R4 rptr advanced
    {2'd1, 4'd9,  12'h01C, 32'h5, 32'h0},
    {2'd0, 4'd9,  12'h01C, 32'h0, 32'h5},        // R9 trig cnt
    {2'd1, 4'd6,  12'h304, 32'h3001, 32'h0},
    {2'd0, 4'd6,  12'h304, 32'h0, 32'h3001},     // R6 readback
    {2'd1, 4'd6,  12'h304, 32'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_req = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d; trc_trig = t;
    @(posedge clk); #1;
    trc_valid = 1'b0; trc_trig = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    trc_valid = 1'b0; trc_data = '0; trc_trig = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][81:80] == 2'd1) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], d);
        chk($sformatf("R%0d vec %0d", VEC[i][79:76], i), d, VEC[i][31:0]);
      end
    end

    // R3 / R5: clear the RAM through the write port; the wrap sets the flag
    wr(12'h018, 0);
    for (int i = 0; i < DEPTH; i++) wr(12'h024, 0);
    rdchk("R3 wrap by bus write", 12'h00C, 1);
    rdchk("R5 wptr wrapped", 12'h018, 0);
    wr(12'h018, 0);
    rdchk("R3 cleared by wptr write", 12'h00C, 0);

    // R2: capture
    wr(12'h020, 1);
    for (int i = 0; i < 5; i++) push(32'hA0 + 32'(i), 1'b0);
    rdchk("R2 wptr after 5", 12'h018, 5);
    wr(12'h014, 0);
    for (int i = 0; i < 5; i++) rdchk("R2 captured word", 12'h010, 32'hA0 + 32'(i));
    for (int i = 0; i < 12; i++) push(32'hB0 + 32'(i), 1'b0);
    rdchk("R2 wptr wrapped", 12'h018, 1);
    rdchk("R3 wrap by trace", 12'h00C, 1);
    wr(12'h020, 0);
    wr(12'h020, 1);
    rdchk("R3 sticky across re-enable", 12'h00C, 1);
    wr(12'h018, 0);

    // R5: bus data write and trace word in the same cycle
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = 12'h024; reg_wdata = 32'h77;
    trc_valid = 1'b1; trc_data = 32'h88;
    @(posedge clk); #1;
    reg_req = 1'b0; reg_we = 1'b0; trc_valid = 1'b0;
    rdchk("R5 single store on collision", 12'h018, 1);
    wr(12'h014, 0);
    rdchk("R5 bus word wins", 12'h010, 32'h77);

    // R2: dropped while disabled
    wr(12'h020, 0);
    push(32'h99, 1'b0);
    rdchk("R2 no capture when off", 12'h018, 1);

    // R7 / R8: flush from wptr=1 with stop after flush
    wr(12'h020, 1);
    wr(12'h304, 32'h1041);
    rdchk("R7 flush busy bit", 12'h304, 32'h1041);
    push(32'hCC, 1'b0);
    repeat (5) @(posedge clk);
    rdchk("R7 flush bit self-clears", 12'h304, 32'h1001);
    rdchk("R7 wptr on frame boundary", 12'h018, 4);
    rdchk("R8 stopped after flush", 12'h300, 32'h2);
    push(32'hDD, 1'b0);
    rdchk("R8 trace dropped when stopped", 12'h018, 4);
    wr(12'h014, 1);
    for (int i = 0; i < 3; i++) rdchk("R7 zero padding", 12'h010, 0);
    wr(12'h020, 1);
    rdchk("R10 restart clears stop", 12'h300, 0);
    push(32'hEE, 1'b0);
    rdchk("R10 capture resumes", 12'h018, 5);

    // R9: stop three words after trigger
    wr(12'h304, 32'h2001);
    wr(12'h01C, 3);
    wr(12'h018, 0);
    wr(12'h020, 1);
    for (int i = 0; i < 6; i++) push(32'h100 + 32'(i), i == 0);
    rdchk("R9 count 3 stored words", 12'h018, 4);
    rdchk("R9 stopped flag", 12'h300, 32'h2);
    wr(12'h014, 3);
    rdchk("R9 last stored word", 12'h010, 32'h103);

    // R9: trigger ignored without stop-on-trigger
    wr(12'h304, 32'h1);
    wr(12'h020, 1);
    wr(12'h018, 0);
    for (int i = 0; i < 6; i++) push(32'h200 + 32'(i), i == 0);
    rdchk("R9 trigger no effect", 12'h018, 6);
    rdchk("R9 not stopped", 12'h300, 0);

    // R9: zero count stops right after trigger word
    wr(12'h304, 32'h2001);
    wr(12'h01C, 0);
    wr(12'h020, 1);
    wr(12'h018, 0);
    push(32'h300, 1'b1);
    push(32'h301, 1'b0);
    rdchk("R9 count 0", 12'h018, 1);
    rdchk("R9 count 0 stopped", 12'h300, 32'h2);

    // R11: reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rdchk("R11 wptr after reset", 12'h018, 0);
    rdchk("R11 ctrl after reset", 12'h020, 0);
    rdchk("R11 fmt ctrl after reset", 12'h304, 0);
    rdchk("R11 trig cnt after reset", 12'h01C, 0);

    summary();
    $finish;
  end
endmodule